// File: doc/BRIEF.md
# Driver Impedance Calibration Sequencer

This block runs a two-stage impedance calibration for an output driver. On a start pulse it steps a 5-bit pull-up code through a fixed set of sweep values. At each code it waits a programmable number of cycles, then samples an external comparator, and it stops at the first code where the comparator reads high. It then holds that pull-up code and steps a 5-bit pull-down/termination code through the same set of values, stopping at the first code where the comparator reads low. While these stages run, the block also selects the reference voltage that the comparator uses.

When both stages are finished, the block forms a set of four results. It publishes them with a one-cycle done pulse. The set depends on whether termination was requested at start. In terminated mode, small codes are scaled up by three. Afterwards the reference select moves to a tracking value. The surrounding logic applies the results to the pads.

Top module: `imp_cal_seq`

## Requirements
- R1: Each stage applies codes in the order 0, 1, …, 15, 29, 30, 31. Codes 16 through 28 never appear on either drive-code output.
- R2: The comparator passes through a two-flop synchronizer. Each applied code is held for SETTLE_CYC cycles (SETTLE_CYC ≥ 3) before the comparator is sampled.
- R3: Stage one sweeps the pull-up code with the pull-down code at 0. It records the first code whose synchronized comparator sample is 1. The pull-up output then stays at that code (or at 31 if no code hit) until the next start.
- R4: Stage two sweeps the pull-down code from 0. It records the first code whose sample is 0, and the pull-down output stays at that code (or 31) afterwards.
- R5: A stage that reaches code 31 without a hit records 255 (8'hFF) as its result.
- R6: With termination off, the results are rslt0_o = pull-up result, rslt1_o = pull-down result, rslt2_o = 0, rslt3_o = 15.
- R7: With termination on, the results are rslt0_o = s(pull-up result), rslt1_o = s(9) = 9, rslt2_o = 0, rslt3_o = s(pull-down result). Here s(v) = 3·v when v ≤ 3, and s(v) = v otherwise.
- R8: With termination on, vref_sel_o is VREF_TERM during calibration and afterwards. With termination off, it is VREF_PU in stage one, VREF_PD in stage two including the final cycle, and VREF_TRK when idle. The termination flag is captured at start.
- R9: done_o is high for exactly one cycle, and the results are valid in that cycle. busy_o is high from the cycle after start until done_o.
- R10: A start pulse while busy_o is high has no effect on the results, the termination mode or the number of done pulses.
- R11: After reset, both codes and all results are 0, done_o and busy_o are 0, and vref_sel_o is VREF_TRK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| term_en_i | input | 1 | Termination-enabled flag, captured at start |
| cmp_i | input | 1 | Asynchronous comparator output |
| pu_code_o | output | 5 | Pull-up drive code |
| pd_code_o | output | 5 | Pull-down/termination drive code |
| vref_sel_o | output | 6 | Comparator reference-voltage select |
| rslt0_o | output | 8 | Result slot 0 |
| rslt1_o | output | 8 | Result slot 1 |
| rslt2_o | output | 8 | Result slot 2 |
| rslt3_o | output | 8 | Result slot 3 |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle results-valid pulse |

## Verification
The bench models the comparator as a pair of thresholds: the pull-up must reach P and the pull-down must stay below N. P runs over every value from 0 to 32 and N over a spread of values, in both termination modes. The resulting patterns tell apart:
- an immediate hit from a hit just after the 15-to-29 jump;
- a hit at the last code from a miss that yields 255;
- small results that must be tripled from those that must pass unchanged.

A miss in stage one changes which pull-up code stage two runs against, so the two stages are checked together rather than in isolation. Reference-select values are checked at the start of stage one, in the final calibration cycle and after done. A start with the opposite termination flag is issued during a long run to show it is ignored.

// File: rtl/imp_cal_pkg.sv
// Shared types and helpers for the impedance calibration sequencer.
// Assumes 5-bit drive codes and 8-bit result slots.
package imp_cal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PU   = 2'd1,
        ST_PD   = 2'd2,
        ST_FIN  = 2'd3
    } cal_state_t;

    localparam logic [7:0] MISS_VAL = 8'hFF;

    // Next code in the sweep: 15 jumps to 29, skipping 16..28.
    function automatic logic [4:0] imp_next_code(input logic [4:0] c);
        return (c == 5'd15) ? 5'd29 : c + 5'd1;
    endfunction

    // Terminated-mode scaling: values up to 3 are tripled.
    function automatic logic [7:0] imp_scale(input logic [7:0] v);
        return (v <= 8'd3) ? v * 8'd3 : v;
    endfunction

endpackage

// File: rtl/imp_cmp_sync.sv
// Multi-flop synchronizer for the asynchronous comparator output.
// Assumes STAGES >= 2; resets to 0.
module imp_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/imp_settle_timer.sv
// Down-counter that marks when a newly applied code has settled.
// A load restarts the interval; expired_o is high after SETTLE_CYC-1
// further cycles. Assumes SETTLE_CYC >= 3.
module imp_settle_timer #(
    parameter int SETTLE_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    // Reload on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load_i)         cnt <= LOAD_VAL;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign expired_o = (cnt == '0);
endmodule

// File: rtl/imp_result_map.sv
// Maps the two sweep results onto the four result slots for the
// captured termination mode. Purely combinational.
module imp_result_map #(
    parameter logic [7:0] FIXED_PD = 8'd9,
    parameter logic [7:0] UNTERM_LAST = 8'd15
) (
    input  logic       term_i,
    input  logic [7:0] pu_res_i,
    input  logic [7:0] pd_res_i,
    output logic [7:0] slot_o [4]
);
    import imp_cal_pkg::*;

    // Choose slot contents by termination mode.
    always_comb begin
        if (term_i) begin
            slot_o[0] = imp_scale(pu_res_i);
            slot_o[1] = imp_scale(FIXED_PD);
            slot_o[2] = 8'd0;
            slot_o[3] = imp_scale(pd_res_i);
        end else begin
            slot_o[0] = pu_res_i;
            slot_o[1] = pd_res_i;
            slot_o[2] = 8'd0;
            slot_o[3] = UNTERM_LAST;
        end
    end
endmodule

// File: rtl/imp_cal_seq.sv
// Two-stage driver impedance calibration sequencer (top).
// Sweeps the pull-up code until the comparator reads 1, then the
// pull-down code until it reads 0, and publishes four results with a
// one-cycle done pulse. Assumes SETTLE_CYC >= 3 so the synchronizer
// output reflects the current code at sampling time.
module imp_cal_seq #(
    parameter int         SETTLE_CYC = 50,
    parameter logic [5:0] VREF_PU    = 6'd14,
    parameter logic [5:0] VREF_PD    = 6'd26,
    parameter logic [5:0] VREF_TRK   = 6'd20,
    parameter logic [5:0] VREF_TERM  = 6'd40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       term_en_i,
    input  logic       cmp_i,
    output logic [4:0] pu_code_o,
    output logic [4:0] pd_code_o,
    output logic [5:0] vref_sel_o,
    output logic [7:0] rslt0_o,
    output logic [7:0] rslt1_o,
    output logic [7:0] rslt2_o,
    output logic [7:0] rslt3_o,
    output logic       busy_o,
    output logic       done_o
);
    import imp_cal_pkg::*;

    localparam logic [4:0] LAST_CODE = 5'd31;

    cal_state_t state;
    logic       term_q;
    logic [4:0] pu_code, pd_code;
    logic [7:0] pu_res, pd_res;
    logic [7:0] rslt [4];
    logic [7:0] map_slot [4];
    logic       done_q;
    logic       cmp_s;
    logic       settled;
    logic       tmr_load;

    imp_cmp_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_i),
        .q_o   (cmp_s)
    );

    imp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (settled)
    );

    imp_result_map u_map (
        .term_i   (term_q),
        .pu_res_i (pu_res),
        .pd_res_i (pd_res),
        .slot_o   (map_slot)
    );

    // Restart the settle interval whenever a new code or stage begins.
    always_comb begin
        tmr_load = 1'b0;
        if (state == ST_IDLE && start_i)                    tmr_load = 1'b1;
        if ((state == ST_PU || state == ST_PD) && settled)  tmr_load = 1'b1;
    end

    // Calibration state machine: sweeps, result capture and publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            term_q  <= 1'b0;
            pu_code <= '0;
            pd_code <= '0;
            pu_res  <= '0;
            pd_res  <= '0;
            done_q  <= 1'b0;
            for (int i = 0; i < 4; i++) rslt[i] <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        term_q  <= term_en_i;
                        pu_code <= '0;
                        pd_code <= '0;
                        state   <= ST_PU;
                    end
                end
                ST_PU: begin
                    if (settled) begin
                        if (cmp_s) begin
                            pu_res <= {3'b000, pu_code};
                            state  <= ST_PD;
                        end else if (pu_code == LAST_CODE) begin
                            pu_res <= MISS_VAL;
                            state  <= ST_PD;
                        end else begin
                            pu_code <= imp_next_code(pu_code);
                        end
                    end
                end
                ST_PD: begin
                    if (settled) begin
                        if (!cmp_s) begin
                            pd_res <= {3'b000, pd_code};
                            state  <= ST_FIN;
                        end else if (pd_code == LAST_CODE) begin
                            pd_res <= MISS_VAL;
                            state  <= ST_FIN;
                        end else begin
                            pd_code <= imp_next_code(pd_code);
                        end
                    end
                end
                default: begin
                    for (int i = 0; i < 4; i++) rslt[i] <= map_slot[i];
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
            endcase
        end
    end

    // Reference select by stage and captured termination mode.
    always_comb begin
        if (term_q)                 vref_sel_o = VREF_TERM;
        else if (state == ST_PU)    vref_sel_o = VREF_PU;
        else if (state == ST_IDLE)  vref_sel_o = VREF_TRK;
        else                        vref_sel_o = VREF_PD;
    end

    assign pu_code_o = pu_code;
    assign pd_code_o = pd_code;
    assign rslt0_o   = rslt[0];
    assign rslt1_o   = rslt[1];
    assign rslt2_o   = rslt[2];
    assign rslt3_o   = rslt[3];
    assign busy_o    = (state != ST_IDLE);
    assign done_o    = done_q;
endmodule

// File: rtl/imp_cal_seq_chk.sv
// Property checker for imp_cal_seq, attached with bind below.
// Tracks how long drive codes are held with a local counter.
module imp_cal_seq_chk #(
    parameter int         SETTLE_CYC = 50,
    parameter logic [5:0] VREF_TERM  = 6'd40
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_o,
    input logic       term_q,
    input logic [4:0] pu_code_o,
    input logic [4:0] pd_code_o,
    input logic [5:0] vref_sel_o,
    input logic [7:0] rslt2_o,
    input logic [7:0] rslt3_o
);
    import imp_cal_pkg::*;

    localparam int HW = $clog2(SETTLE_CYC + 1) + 1;
    localparam logic [HW-1:0] HOLD_MAX = {HW{1'b1}};
    localparam logic [HW-1:0] HOLD_MIN = HW'(SETTLE_CYC - 1);

    logic [4:0]    pu_prev, pd_prev;
    logic [HW-1:0] hold;
    logic          chg;

    assign chg = (pu_code_o != pu_prev) || (pd_code_o != pd_prev);

    // Remember last codes and count cycles since the last code change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_prev <= '0;
            pd_prev <= '0;
            hold    <= '0;
        end else begin
            pu_prev <= pu_code_o;
            pd_prev <= pd_code_o;
            if (chg)                  hold <= '0;
            else if (hold != HOLD_MAX) hold <= hold + 1'b1;
        end
    end

    assert_code_skip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !((pu_code_o >= 5'd16 && pu_code_o <= 5'd28) ||
          (pd_code_o >= 5'd16 && pd_code_o <= 5'd28)));

    assert_pu_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && pu_code_o != $past(pu_code_o))
        |-> pu_code_o == imp_next_code($past(pu_code_o)));

    assert_pd_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && pd_code_o != $past(pd_code_o))
        |-> pd_code_o == imp_next_code($past(pd_code_o)));

    assert_settle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && busy_o && $past(busy_o)) |-> hold >= HOLD_MIN);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_unterm_slots_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !term_q) |-> (rslt2_o == 8'd0 && rslt3_o == 8'd15));

    assert_vref_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
        term_q |-> vref_sel_o == VREF_TERM);
endmodule

bind imp_cal_seq imp_cal_seq_chk #(
    .SETTLE_CYC (SETTLE_CYC),
    .VREF_TERM  (VREF_TERM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .term_q     (term_q),
    .pu_code_o  (pu_code_o),
    .pd_code_o  (pd_code_o),
    .vref_sel_o (vref_sel_o),
    .rslt2_o    (rslt2_o),
    .rslt3_o    (rslt3_o)
);

// File: tb/imp_cal_seq_bench.sv
// Self-checking bench: threshold comparator model, sweep over thresholds
// and termination modes, expected values computed arithmetically.
module imp_cal_seq_bench;
    localparam int         SETTLE = 4;
    localparam logic [5:0] V_PU   = 6'd14;
    localparam logic [5:0] V_PD   = 6'd26;
    localparam logic [5:0] V_TRK  = 6'd20;
    localparam logic [5:0] V_TERM = 6'd40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic term_en_i = 1'b0;
    logic cmp_i;
    logic [4:0] pu_code_o, pd_code_o;
    logic [5:0] vref_sel_o;
    logic [7:0] rslt0_o, rslt1_o, rslt2_o, rslt3_o;
    logic busy_o, done_o;

    int thr_p = 32;
    int thr_n = 0;
    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    // Comparator model: high when pull-up reaches P and pull-down is below N.
    assign cmp_i = (int'(pu_code_o) >= thr_p) && !(int'(pd_code_o) >= thr_n);

    imp_cal_seq #(
        .SETTLE_CYC (SETTLE),
        .VREF_PU    (V_PU),
        .VREF_PD    (V_PD),
        .VREF_TRK   (V_TRK),
        .VREF_TERM  (V_TERM)
    ) u_imp_cal_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .term_en_i(term_en_i),
        .cmp_i(cmp_i), .pu_code_o(pu_code_o), .pd_code_o(pd_code_o),
        .vref_sel_o(vref_sel_o), .rslt0_o(rslt0_o), .rslt1_o(rslt1_o),
        .rslt2_o(rslt2_o), .rslt3_o(rslt3_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (P=%0d N=%0d)", req, act, exp, thr_p, thr_n);
        end
    endtask

    function automatic int nxt(input int c);
        return (c == 15) ? 29 : c + 1;
    endfunction

    function automatic bit model(input int pu, input int pd, input int p, input int n);
        return (pu >= p) && !(pd >= n);
    endfunction

    function automatic int scl(input int v);
        return (v <= 3) ? 3 * v : v;
    endfunction

    // One calibration run with expected values derived from the sweep rules.
    task automatic run(input int p, input int n, input bit term, input bit poke);
        int pu_f, pd_f, pu_r, pd_r, cnt;
        int e0, e1, e2, e3;
        logic [5:0] prev_v;
        bit hit;
        // R1/R3/R5: stage-one expectation
        pu_f = 0; hit = 0;
        while (1) begin
            if (model(pu_f, 0, p, n)) begin hit = 1; break; end
            if (pu_f == 31) break;
            pu_f = nxt(pu_f);
        end
        pu_r = hit ? pu_f : 255;
        // R4/R5: stage-two expectation
        pd_f = 0; hit = 0;
        while (1) begin
            if (!model(pu_f, pd_f, p, n)) begin hit = 1; break; end
            if (pd_f == 31) break;
            pd_f = nxt(pd_f);
        end
        pd_r = hit ? pd_f : 255;
        if (term) begin e0 = scl(pu_r); e1 = scl(9); e2 = 0; e3 = scl(pd_r); end
        else      begin e0 = pu_r; e1 = pd_r; e2 = 0; e3 = 15; end

        thr_p = p; thr_n = n;
        @(negedge clk); start_i = 1'b1; term_en_i = term;
        @(negedge clk); start_i = 1'b0; term_en_i = ~term;
        check("R9 busy", int'(busy_o), 1);
        check("R8 vref stage1", int'(vref_sel_o), term ? int'(V_TERM) : int'(V_PU));
        cnt = 0; prev_v = vref_sel_o;
        while (!done_o && cnt < 2000) begin
            prev_v = vref_sel_o;
            @(negedge clk);
            cnt++;
            if (poke && cnt == 5) begin start_i = 1'b1; term_en_i = ~term; end
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        check("R9 done seen", int'(done_o), 1);
        if (term) begin
            check("R7 slot0", int'(rslt0_o), e0);
            check("R7 slot1", int'(rslt1_o), e1);
            check("R7 slot2", int'(rslt2_o), e2);
            check("R7 slot3", int'(rslt3_o), e3);
        end else begin
            check("R6 slot0", int'(rslt0_o), e0);
            check("R6 slot1", int'(rslt1_o), e1);
            check("R6 slot2", int'(rslt2_o), e2);
            check("R6 slot3", int'(rslt3_o), e3);
        end
        check("R3 pu hold", int'(pu_code_o), pu_f);
        check("R4 pd hold", int'(pd_code_o), pd_f);
        check("R8 vref stage2", int'(prev_v), term ? int'(V_TERM) : int'(V_PD));
        @(negedge clk);
        check("R9 done width", int'(done_o), 0);
        check("R8 vref after", int'(vref_sel_o), term ? int'(V_TERM) : int'(V_TRK));
    endtask

    // Watchdog: a hung run is a failed check and still ends with the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<=190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int nlist [6] = '{0, 1, 2, 5, 16, 30};
        int dn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 pu", int'(pu_code_o), 0);
        check("R11 pd", int'(pd_code_o), 0);
        check("R11 slot0", int'(rslt0_o), 0);
        check("R11 slot3", int'(rslt3_o), 0);
        check("R11 done", int'(done_o), 0);
        check("R11 busy", int'(busy_o), 0);
        check("R11 vref", int'(vref_sel_o), int'(V_TRK));

        // R1..R9: near-exhaustive threshold sweep in both modes
        for (int t = 0; t < 2; t++)
            for (int p = 0; p <= 32; p++)
                for (int k = 0; k < 6; k++)
                    run(p, nlist[k], t[0], 1'b0);

        // R10: start while busy, with the opposite termination flag
        run(32, 30, 1'b1, 1'b1);
        run(32, 2, 1'b0, 1'b1);
        dn = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done_o) dn++;
        end
        check("R10 extra done", dn, 0);
        check("R10 idle", int'(busy_o), 0);
        check("R10 slot3 kept", int'(rslt3_o), 15);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule